// File: doc/BRIEF.md
# Page-Table Walking Address Translator

This block turns a 24-bit virtual address into a 32-bit physical address. Memory is split into 8 KB pages, and a one-level table of 4-byte entries held in memory maps each page to a frame. Two inputs place the table: a base address and a length that counts entries. For each accepted request the block reads one entry over a single-beat read port. It checks the entry's flags and then returns either the physical address or a fault code.

A paging-enable input selects pass-through mode. In that mode the virtual address is returned zero-extended, and no memory read is made. The block handles one translation at a time. It shows it is free on a ready output and returns each result as a one-cycle response pulse.

Top module: `pageWalkMmu`

## Requirements
- R1: On a successful translation, physical bits 12..0 equal virtual bits 12..0 of the accepted request.
- R2: On a successful translation, physical bits 31..13 equal bits 31..13 of the fetched entry. The page number is virtual bits 23..13.
- R3: With paging enabled and the page number below the length input, exactly one entry read is issued. Its address is the base input plus four times the page number. The read is issued in the cycle after acceptance.
- R4: With paging disabled at acceptance, the response comes in the cycle after acceptance. The physical address is the virtual address with its upper 8 bits zero, the fault code is 0, and no read is issued.
- R5: With paging enabled and the page number equal to or above the length input, the response comes in the cycle after acceptance. The fault code is 1 (bounds), the address is zero, and no read is issued.
- R6: A fetched entry with bit 0 (valid) clear gives fault code 2, with a zero address. This code is reported even when a write meets a clear bit 1.
- R7: A write access to a valid entry with bit 1 (writable) clear gives fault code 3, with a zero address. A read access to the same entry succeeds with code 0.
- R8: Entry bits 12..2 (dirty at bit 3, referenced at bit 2, and the nine spare bits) have no effect on the result.
- R9: The ready output is high while idle and low from the cycle after acceptance until the response cycle has ended. Only one translation is outstanding at a time.
- R10: The read strobe and the response strobe are each high for exactly one cycle per translation. The response follows, by one cycle, the edge that samples the read-data valid input.
- R11: While reset is asserted, ready is high and both the read strobe and the response strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pagingOn | input | 1 | 1 translates through the table, 0 passes the address through |
| tableBase | input | 32 | Byte address of table entry 0 |
| tableLen | input | 12 | Number of valid table entries (0 to 2048) |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqVaddr | input | 24 | Virtual address |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| memReq | output | 1 | Entry read strobe |
| memAddr | output | 32 | Entry read address |
| memRespValid | input | 1 | Entry read data valid |
| memRespData | input | 32 | Entry read data |
| rspValid | output | 1 | Response strobe |
| rspPaddr | output | 32 | Physical address (zero on a fault) |
| rspFault | output | 2 | 0 ok, 1 bounds, 2 invalid entry, 3 write protect |

## Verification
A pass-through or bounds request is answered one cycle after the edge that accepts it. The bench therefore checks the response at the first falling edge after acceptance, and at that same point confirms that no read strobe is present. For a table walk, the read strobe appears one cycle after acceptance. The entry data is driven only once the block is waiting for it, after a chosen number of extra cycles. The response is checked at the falling edge that follows the edge which took the data. On the next falling edge the bench confirms that both strobes have dropped and ready is back.

// File: rtl/pageWalkPkg.sv
package pageWalkPkg;
  localparam int DEF_VA_W  = 24;
  localparam int DEF_PA_W  = 32;
  localparam int DEF_OFF_W = 13;

  localparam int BIT_VALID = 0;
  localparam int BIT_WRITE = 1;
  localparam int BIT_REF   = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_BOUNDS  = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROTECT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walkState_e;

  typedef enum logic [1:0] {
    KIND_XLAT,
    KIND_BYPASS,
    KIND_BOUNDS
  } reqKind_e;

  typedef struct packed {
    logic takeReq;
    logic takePte;
    logic asBypass;
    logic asBounds;
  } walkStrobe_t;
endpackage

// File: rtl/pageWalkCtrl.sv
module pageWalkCtrl
  import pageWalkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pagingOn,
  input  logic        pageInRange,
  input  logic        memRespValid,
  output logic        reqReady,
  output logic        memReq,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  walkState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.takeReq = 1'b1;
          if (!pagingOn) begin
            strobe.asBypass = 1'b1;
            stateNext       = ST_RESP;
          end else if (!pageInRange) begin
            strobe.asBounds = 1'b1;
            stateNext       = ST_RESP;
          end else begin
            stateNext = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        memReq    = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRespValid) begin
          strobe.takePte = 1'b1;
          stateNext      = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pageWalkPath.sv
module pageWalkPath
  import pageWalkPkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFF_W = DEF_OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [PA_W-1:0]   tableBase,
  input  logic [VA_W-OFF_W:0] tableLen,
  input  logic [PA_W-1:0]   memRespData,
  output logic              pageInRange,
  output logic [PA_W-1:0]   memAddr,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int PAD_W   = PA_W - VA_W;

  logic [VA_W-1:0]    vaddrQ;
  logic               writeQ;
  logic [PA_W-1:0]    entryAddrQ;
  logic [FRAME_W-1:0] frameQ;
  logic               validQ;
  logic               writableQ;
  reqKind_e           kindQ;
  logic [PAGE_W-1:0]  reqPage;
  logic [PA_W-1:0]    bypassAddr;
  logic               unusedPteBits;

  assign reqPage       = reqVaddr[VA_W-1:OFF_W];
  assign pageInRange   = {1'b0, reqPage} < tableLen;
  assign unusedPteBits = ^memRespData[OFF_W-1:BIT_REF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      writeQ     <= 1'b0;
      entryAddrQ <= '0;
      kindQ      <= KIND_BOUNDS;
    end else if (strobe.takeReq) begin
      vaddrQ     <= reqVaddr;
      writeQ     <= reqWrite;
      entryAddrQ <= tableBase + (PA_W'(reqPage) << 2);
      kindQ      <= strobe.asBypass ? KIND_BYPASS :
                    strobe.asBounds ? KIND_BOUNDS : KIND_XLAT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ    <= '0;
      validQ    <= 1'b0;
      writableQ <= 1'b0;
    end else if (strobe.takePte) begin
      frameQ    <= memRespData[PA_W-1:OFF_W];
      validQ    <= memRespData[BIT_VALID];
      writableQ <= memRespData[BIT_WRITE];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign bypassAddr = {{PAD_W{1'b0}}, vaddrQ};
    end else begin : g_trunc
      assign bypassAddr = vaddrQ[PA_W-1:0];
    end
  endgenerate

  assign memAddr = entryAddrQ;

  always_comb begin
    rspPaddr = '0;
    rspFault = FLT_NONE;
    unique case (kindQ)
      KIND_BYPASS: rspPaddr = bypassAddr;
      KIND_BOUNDS: rspFault = FLT_BOUNDS;
      default: begin
        if (!validQ)                   rspFault = FLT_INVALID;
        else if (writeQ && !writableQ) rspFault = FLT_PROTECT;
        else rspPaddr = {frameQ, vaddrQ[OFF_W-1:0]};
      end
    endcase
  end
endmodule

// File: rtl/pageWalkMmu.sv
module pageWalkMmu
  import pageWalkPkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFF_W = DEF_OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pagingOn,
  input  logic [PA_W-1:0]     tableBase,
  input  logic [VA_W-OFF_W:0] tableLen,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  output logic                memReq,
  output logic [PA_W-1:0]     memAddr,
  input  logic                memRespValid,
  input  logic [PA_W-1:0]     memRespData,
  output logic                rspValid,
  output logic [PA_W-1:0]     rspPaddr,
  output logic [1:0]          rspFault
);
  walkStrobe_t strobe;
  logic        pageInRange;

  pageWalkCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .pagingOn    (pagingOn),
    .pageInRange (pageInRange),
    .memRespValid(memRespValid),
    .reqReady    (reqReady),
    .memReq      (memReq),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  pageWalkPath #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .tableBase  (tableBase),
    .tableLen   (tableLen),
    .memRespData(memRespData),
    .pageInRange(pageInRange),
    .memAddr    (memAddr),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault)
  );
endmodule

// File: rtl/pageWalkChk.sv
module pageWalkChk
  import pageWalkPkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFF_W = DEF_OFF_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                pagingOn,
  input logic [PA_W-1:0]     tableBase,
  input logic [VA_W-OFF_W:0] tableLen,
  input logic                reqValid,
  input logic                reqReady,
  input logic [VA_W-1:0]     reqVaddr,
  input logic                reqWrite,
  input logic                memReq,
  input logic [PA_W-1:0]     memAddr,
  input logic                memRespValid,
  input logic [PA_W-1:0]     memRespData,
  input logic                rspValid,
  input logic [PA_W-1:0]     rspPaddr,
  input logic [1:0]          rspFault
);
  localparam int PAGE_W = VA_W - OFF_W;

  logic [OFF_W-1:0]  offSeen;
  logic [PA_W-1:0]   entrySeen;
  logic [PAGE_W-1:0] pageNow;
  logic              accepted;
  logic              unusedChk;

  assign pageNow   = reqVaddr[VA_W-1:OFF_W];
  assign accepted  = reqValid && reqReady;
  assign unusedChk = ^{reqWrite, memRespValid, memRespData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offSeen   <= '0;
      entrySeen <= '0;
    end else if (accepted) begin
      offSeen   <= reqVaddr[OFF_W-1:0];
      entrySeen <= tableBase + {{(PA_W-PAGE_W-2){1'b0}}, pageNow, 2'b00};
    end
  end

  // R10: single-cycle strobes
  a_r10_memreq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9: one translation outstanding
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !reqReady);

  // R4: pass-through answered next cycle without a read
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !pagingOn) |=> (rspValid && !memReq && rspFault == 2'd0 &&
      rspPaddr == {{(PA_W-VA_W){1'b0}}, $past(reqVaddr)}));

  // R5: out-of-range page answered next cycle without a read
  a_r5_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && pagingOn && ({1'b0, pageNow} >= tableLen)) |=>
      (rspValid && !memReq && rspFault == 2'd1 && rspPaddr == '0));

  // R3: entry address
  a_r3_entry_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr == entrySeen);

  // R1: offset carried through
  a_r1_offset: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> rspPaddr[OFF_W-1:0] == offSeen);
endmodule

bind pageWalkMmu pageWalkChk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/pageWalkMmu_tb.sv
`timescale 1ns/1ps
module pageWalkMmu_tb;
  typedef struct packed {
    logic        pg;
    logic        wr;
    logic [23:0] va;
    logic [31:0] pte;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 24'h021ABC, 32'hABCDE001, 4'd0},  // read, valid
    '{1'b1, 1'b1, 24'h035555, 32'h12346003, 4'd2},  // write, writable
    '{1'b1, 1'b1, 24'h041234, 32'h55554001, 4'd1},  // write, read-only
    '{1'b1, 1'b0, 24'h041234, 32'h55554001, 4'd0},  // read, read-only
    '{1'b1, 1'b0, 24'h001FFF, 32'hFFFFE002, 4'd3},  // invalid
    '{1'b1, 1'b1, 24'h006000, 32'h0000E000, 4'd0},  // invalid + write
    '{1'b0, 1'b1, 24'hFFFFFF, 32'h00000000, 4'd0},  // pass-through
    '{1'b1, 1'b0, 24'h080000, 32'h00000001, 4'd0},  // page 64, bounds
    '{1'b1, 1'b0, 24'h07E000, 32'h7654A001, 4'd1},  // page 63, last in range
    '{1'b0, 1'b0, 24'h000010, 32'h00000000, 4'd0}   // pass-through low
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pagingOn = 1'b0;
  logic [31:0] tableBase = 32'h0004_0000;
  logic [11:0] tableLen = 12'd64;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  pageWalkMmu u_dut (
    .clk(clk), .rstN(rstN), .pagingOn(pagingOn), .tableBase(tableBase),
    .tableLen(tableLen), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .memReq(memReq),
    .memAddr(memAddr), .memRespValid(memRespValid), .memRespData(memRespData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected {fault, paddr} straight from the requirements
  function automatic logic [33:0] model(input bit pg, input bit wr,
      input logic [23:0] va, input logic [31:0] pte, input logic [11:0] len);
    logic [10:0] pg_n = va[23:13];
    if (!pg)                 return {2'd0, 8'h00, va};
    if ({1'b0, pg_n} >= len) return {2'd1, 32'h0};
    if (!pte[0])             return {2'd2, 32'h0};
    if (wr && !pte[1])       return {2'd3, 32'h0};
    return {2'd0, pte[31:13], va[12:0]};
  endfunction

  function automatic string tagFor(input logic [33:0] e, input bit pg);
    if (!pg)                return "R4";
    if (e[33:32] == 2'd1)   return "R5";
    if (e[33:32] == 2'd2)   return "R6";
    if (e[33:32] == 2'd3)   return "R7";
    return "R2";
  endfunction

  task automatic runTxn(input bit pg, input bit wr, input logic [23:0] va,
                        input logic [31:0] pte, input int lat, input string tag);
    logic [33:0] e = model(pg, wr, va, pte, tableLen);
    bit expRead = pg && ({1'b0, va[23:13]} < tableLen);
    @(negedge clk);
    check(reqReady == 1'b1, "R9 idle ready", 64'(reqReady), 64'd1);
    reqValid = 1'b1; pagingOn = pg; reqWrite = wr; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", 64'(reqReady), 64'd0);
    if (expRead) begin
      check(memReq == 1'b1, "R3 read issued", 64'(memReq), 64'd1);
      check(memAddr == tableBase + {19'd0, va[23:13], 2'b00}, "R3 entry address",
            64'(memAddr), 64'(tableBase + {19'd0, va[23:13], 2'b00}));
      @(negedge clk);
      check(memReq == 1'b0, "R10 read strobe one cycle", 64'(memReq), 64'd0);
      repeat (lat) @(negedge clk);
      memRespValid = 1'b1; memRespData = pte;
      @(negedge clk);
      memRespValid = 1'b0; memRespData = '0;
    end else begin
      check(memReq == 1'b0, {tag, " no read"}, 64'(memReq), 64'd0);
    end
    check(rspValid == 1'b1, {tag, " response due"}, 64'(rspValid), 64'd1);
    check(rspFault == e[33:32], {tag, " fault code"}, 64'(rspFault), 64'(e[33:32]));
    check(rspPaddr == e[31:0], {tag, " physical address"}, 64'(rspPaddr), 64'(e[31:0]));
    if (e[33:32] == 2'd0)
      check(rspPaddr[12:0] == va[12:0], "R1 offset", 64'(rspPaddr[12:0]), 64'(va[12:0]));
    @(negedge clk);
    check(rspValid == 1'b0, "R10 response one cycle", 64'(rspValid), 64'd0);
    check(reqReady == 1'b1, "R9 ready again", 64'(reqReady), 64'd1);
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1, "R11 ready in reset", 64'(reqReady), 64'd1);
    check(memReq == 1'b0, "R11 no read in reset", 64'(memReq), 64'd0);
    check(rspValid == 1'b0, "R11 no response in reset", 64'(rspValid), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [33:0] e = model(VECS[i].pg, VECS[i].wr, VECS[i].va, VECS[i].pte, tableLen);
      runTxn(VECS[i].pg, VECS[i].wr, VECS[i].va, VECS[i].pte, int'(VECS[i].lat),
             tagFor(e, VECS[i].pg));
    end

    // R8: flag and spare bits set, result must match the bare entry
    runTxn(1'b1, 1'b0, 24'h02ABCD, 32'h9ABCDFFD, 0, "R8");
    runTxn(1'b1, 1'b0, 24'h02ABCD, 32'h9ABCC001, 0, "R8 bare");
    // R7: read-only entry with dirty and referenced set, written
    runTxn(1'b1, 1'b1, 24'h02ABCD, 32'h9ABCC00D, 0, "R7");
    // R10: long read latency
    runTxn(1'b1, 1'b0, 24'h010101, 32'h00002003, 9, "R10");
    // R5: empty table faults every page
    tableLen = 12'd0;
    runTxn(1'b1, 1'b0, 24'h000000, 32'h00000001, 0, "R5");
    // R2: full table, last page, different base
    tableLen  = 12'd2048;
    tableBase = 32'hFFF0_0000;
    runTxn(1'b1, 1'b1, 24'hFFE123, 32'hFFFFE003, 2, "R2");
    runTxn(1'b1, 1'b0, 24'h000000, 32'h00000001, 0, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule